// File: doc/BRIEF.md
# Serial Video Link Transmit Encoder

This block turns parallel video words into the serial bit stream of a coaxial digital video link. It runs on the bit clock, which is ten times the word rate. A one-cycle load strobe marks each word boundary. On that strobe the block captures a word and shifts it out least significant bit first, one bit per bit clock. Each bit then goes through a self-synchronizing scrambler. The scrambler XORs the bit with the scrambled bits sent five and nine bit periods earlier. Because it works only from its own output history, no scrambler state is ever sent to the far end. Last, a transition coder turns every scrambled one into a change of line level, so the receiver does not care about polarity.

The block accepts words of up to ten bits. In 8-bit mode the sample sits in the upper eight bits of the word input, and the block forces the two low bits to zero. One exception applies: an all-ones sample is a timing-reference word, and it is sent as ten ones so that the receiver's sync pattern stays intact. In 10-bit mode every word passes unchanged, so ancillary data is not altered.

Top module: `sdi_tx_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, `serial_out` is 0 after that edge. The scrambler history and the shift register are cleared, so a stream sent after reset does not depend on traffic sent before it.
- R2: A word is captured at the edge where `word_valid` is high. Bit k (k = 0 is the LSB) decides whether `serial_out` changes at the (k+1)-th edge after the capture edge.
- R3: If `word_valid` is pulsed every 10 cycles, consecutive words go out with no idle bit between them.
- R4: The scrambled bit is s[n] = d[n] XOR s[n-5] XOR s[n-9], where d is the serializer bit and s before reset release counts as 0.
- R5: `serial_out` toggles after an edge exactly when the scrambled bit of that cycle is 1, and holds its level otherwise.
- R6: With `narrow_mode` high at capture, the word sent is `word_in[9:2]` followed by two zero bits in positions [1:0], whatever `word_in[1:0]` holds.
- R7: With `narrow_mode` high at capture and `word_in[9:2]` equal to 8'hFF, the word sent is 10'h3FF.
- R8: With `narrow_mode` low at capture, all ten bits of `word_in` are sent unchanged, including 10'h3FF and 10'h000.
- R9: `word_in` and `narrow_mode` are sampled only at the capture edge. Changes to them while a word is shifting out have no effect on that word.
- R10: When no new word is captured, the serializer feeds zero data bits into the scrambler after the last bit of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, ten times the word rate |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 10 | Parallel video word; in 8-bit mode the sample is in bits [9:2] |
| word_valid | input | 1 | One-cycle word boundary marker; captures `word_in` |
| narrow_mode | input | 1 | 1 selects 8-bit samples, 0 selects 10-bit words |
| serial_out | output | 1 | Scrambled, transition-coded serial bit |

## Verification
The hardest thing to observe is the scrambler's recursion. The port shows only levels, and each level depends on every earlier scrambled bit. A single wrong tap or a stale history bit can therefore hide among many correct-looking bits.

The bench handles this in two ways. First, it sends one lone set bit from a freshly reset state. This makes the five- and nine-period echoes appear as isolated level changes at predictable positions. The bench runs this case once after power-up and again after a reset in mid-traffic, which shows that the history is cleared. Second, for all other traffic the bench undoes the transition coding and the scrambling on the observed line. It then rebuilds the words at their known bit positions and compares them with the words the requirements call for.

// File: rtl/sdi_tx_pkg.sv
package sdi_tx_pkg;

    // Default geometry of the link word and the scrambler taps
    localparam int DEF_WORD_W   = 10;
    localparam int DEF_NARROW_W = 8;
    localparam int DEF_TAP_NEAR = 5;
    localparam int DEF_TAP_FAR  = 9;

    // Line level after one bit period of transition coding
    function automatic logic nrzi_step(input logic level, input logic bit_in);
        return level ^ bit_in;
    endfunction

    // Scrambled bit from the data bit and two history taps
    function automatic logic scramble_bit(input logic d, input logic near_tap,
                                          input logic far_tap);
        return d ^ near_tap ^ far_tap;
    endfunction

endpackage

// File: rtl/sdi_word_pad.sv
module sdi_word_pad
    import sdi_tx_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int NARROW_W = DEF_NARROW_W
) (
    input  logic [WORD_W-1:0] din,
    input  logic              narrow,
    output logic [WORD_W-1:0] dout
);
    localparam int PAD_W = WORD_W - NARROW_W;

    generate
        if (PAD_W <= 0) begin : g_no_pad
            // A narrow sample already fills the word: nothing to pad
            logic unused_narrow;
            assign unused_narrow = narrow;
            assign dout = din;
        end else begin : g_pad
            logic [NARROW_W-1:0] sample;
            assign sample = din[WORD_W-1 -: NARROW_W];
            always_comb begin
                if (!narrow) begin
                    dout = din;
                end else if (&sample) begin
                    // Timing-reference ones word is widened to all ones
                    dout = '1;
                end else begin
                    dout = {sample, {PAD_W{1'b0}}};
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sdi_serializer.sv
module sdi_serializer
    import sdi_tx_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic              ser_bit
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  left;
    } ser_state_t;

    ser_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.shreg = din;
            st_d.left  = CNT_W'(WORD_W);
        end else begin
            st_d.shreg = st_q.shreg >> 1;
            if (st_q.left != '0) begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_bit = st_q.shreg[0];

    // A new word may only arrive once the last bit of the previous one is on the line
    assert_load_on_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> (st_q.left <= CNT_W'(1)));

endmodule

// File: rtl/sdi_scrambler.sv
module sdi_scrambler
    import sdi_tx_pkg::*;
#(
    parameter int TAP_NEAR = DEF_TAP_NEAR,
    parameter int TAP_FAR  = DEF_TAP_FAR
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    // hist[k] holds the scrambled bit from k+1 periods ago
    logic [TAP_FAR-1:0] hist;

    generate
        if (TAP_FAR < 2 || TAP_NEAR < 1 || TAP_NEAR >= TAP_FAR) begin : g_bad_taps
            initial $error("sdi_scrambler: taps must satisfy 1 <= near < far, far >= 2");
        end
    endgenerate

    assign dout = scramble_bit(din, hist[TAP_NEAR-1], hist[TAP_FAR-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[TAP_FAR-2:0], dout};
        end
    end
endmodule

// File: rtl/sdi_nrzi.sv
module sdi_nrzi
    import sdi_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
        end else begin
            level <= nrzi_step(level, din);
        end
    end
endmodule

// File: rtl/sdi_tx_encoder.sv
module sdi_tx_encoder
    import sdi_tx_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int NARROW_W = DEF_NARROW_W,
    parameter int TAP_NEAR = DEF_TAP_NEAR,
    parameter int TAP_FAR  = DEF_TAP_FAR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    input  logic              narrow_mode,
    output logic              serial_out
);
    logic [WORD_W-1:0] padded;
    logic              ser_bit;
    logic              scr_bit;

    sdi_word_pad #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_pad (
        .din    (word_in),
        .narrow (narrow_mode),
        .dout   (padded)
    );

    sdi_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .load    (word_valid),
        .din     (padded),
        .ser_bit (ser_bit)
    );

    sdi_scrambler #(.TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)) u_scr (
        .clk  (clk),
        .rst  (rst),
        .din  (ser_bit),
        .dout (scr_bit)
    );

    sdi_nrzi u_nrzi (
        .clk   (clk),
        .rst   (rst),
        .din   (scr_bit),
        .level (serial_out)
    );

    // Reset drives the line low
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !serial_out);

    // The first bit on the serializer after a capture is the padded LSB
    assert_lsb_first_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(word_valid) && !$past(rst)) |-> (ser_bit == $past(padded[0])));

    // A line change happens exactly when the scrambled bit was one
    assert_transition_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((serial_out ^ $past(serial_out)) == $past(scr_bit)));

    // A narrow sample that is not all ones starts with a zero pad bit
    assert_narrow_pad_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(word_valid) && !$past(rst) && $past(narrow_mode)
         && ($past(word_in[WORD_W-1 -: NARROW_W]) != '1)) |-> !ser_bit);

endmodule

// File: tb/test_sdi_tx_encoder.sv
module test_sdi_tx_encoder;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] word_in;
    logic       word_valid;
    logic       narrow_mode;
    logic       serial_out;

    int n_tests = 0;
    int n_fail  = 0;

    // Receive-side model: undoes transition coding and scrambling on the line
    logic       rx_bit [0:2047];
    logic       rx_lvl [0:2047];
    int         rxn;
    logic       prev_lvl;
    logic [8:0] dhist;

    always #5 clk = ~clk;

    sdi_tx_encoder i_sdi_tx_encoder (
        .clk         (clk),
        .rst         (rst),
        .word_in     (word_in),
        .word_valid  (word_valid),
        .narrow_mode (narrow_mode),
        .serial_out  (serial_out)
    );

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        rxn = 0;
        prev_lvl = 1'b0;
        dhist = '0;
    endtask

    // One bit period: sample away from the edge, then descramble
    task automatic tick();
        logic cur, s, d;
        @(negedge clk);
        cur = serial_out;
        s = cur ^ prev_lvl;
        prev_lvl = cur;
        d = s ^ dhist[4] ^ dhist[8];
        dhist = {dhist[7:0], s};
        rx_lvl[rxn] = cur;
        rx_bit[rxn] = d;
        rxn++;
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        word_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 line low in reset", {31'd0, serial_out}, 32'd0);
        end
        rst = 1'b0;
        model_clear();
    endtask

    // Send one word; returns index in rx arrays of its bit 0.
    // Inputs are disturbed while shifting to show they are ignored (R9).
    task automatic send_word(input logic [9:0] w, input logic nar, output int base);
        word_in = w;
        narrow_mode = nar;
        word_valid = 1'b1;
        base = rxn + 1;
        tick();
        word_valid = 1'b0;
        word_in = ~w;
        narrow_mode = ~nar;
        for (int i = 0; i < 9; i++) tick();
    endtask

    function automatic logic [9:0] rx_word(input int base);
        logic [9:0] w;
        for (int k = 0; k < 10; k++) w[k] = rx_bit[base + k];
        return w;
    endfunction

    // Lone LSB from clean state: levels 1,1,1,1,1,0,0,0,0,1 (echoes at 5 and 9)
    task automatic t_lone_bit(input string tag);
        int b;
        logic [9:0] exp_lv;
        exp_lv = 10'b10_0001_1111;  // bit k = level for data bit k
        send_word(10'h001, 1'b0, b);
        tick();
        check({tag, " R2 line unchanged before first bit"}, {31'd0, rx_lvl[b-1]}, 32'd0);
        for (int k = 0; k < 10; k++)
            check({tag, " R4 R5 level pattern"}, {31'd0, rx_lvl[b+k]}, {31'd0, exp_lv[k]});
    endtask

    task automatic t_wide();
        int b0, b1, b2, b3;
        send_word(10'h3FF, 1'b0, b0);
        send_word(10'h000, 1'b0, b1);
        send_word(10'h2A5, 1'b0, b2);
        send_word(10'h17C, 1'b0, b3);
        tick();
        check("R8 wide all ones", {22'd0, rx_word(b0)}, 32'h3FF);
        check("R8 wide zero", {22'd0, rx_word(b1)}, 32'h000);
        check("R8 R3 wide 2A5 back to back", {22'd0, rx_word(b2)}, 32'h2A5);
        check("R3 R9 wide 17C back to back", {22'd0, rx_word(b3)}, 32'h17C);
        check("R3 no gap between words", b1 - b0, 10);
    endtask

    task automatic t_narrow();
        int b0, b1, b2, b3;
        send_word(10'h2AB, 1'b1, b0);
        send_word(10'h3FD, 1'b1, b1);
        send_word(10'h3FB, 1'b1, b2);
        send_word(10'h003, 1'b1, b3);
        tick();
        check("R6 narrow low bits zeroed", {22'd0, rx_word(b0)}, 32'h2A8);
        check("R7 narrow ones widened", {22'd0, rx_word(b1)}, 32'h3FF);
        check("R6 narrow near-ones", {22'd0, rx_word(b2)}, 32'h3F8);
        check("R6 narrow zero sample", {22'd0, rx_word(b3)}, 32'h000);
    endtask

    // Mode flips to narrow right after a wide capture: word must stay intact
    task automatic t_mode_sampled();
        int b;
        send_word(10'h1FE, 1'b0, b);
        tick();
        check("R9 mode change mid-word ignored", {22'd0, rx_word(b)}, 32'h1FE);
    endtask

    task automatic t_idle();
        int b;
        logic [15:0] tail;
        send_word(10'h355, 1'b0, b);
        for (int i = 0; i < 17; i++) tick();
        check("R2 word before idle", {22'd0, rx_word(b)}, 32'h355);
        for (int k = 0; k < 16; k++) tail[k] = rx_bit[b + 10 + k];
        check("R10 idle data bits are zero", {16'd0, tail}, 32'd0);
    endtask

    initial begin
        word_in = '0;
        word_valid = 1'b0;
        narrow_mode = 1'b0;
        model_clear();
        apply_reset();
        t_lone_bit("first");
        t_wide();
        t_narrow();
        t_mode_sampled();
        t_idle();
        // Reset after traffic must clear scrambler history (R1)
        @(negedge clk);
        apply_reset();
        t_lone_bit("after R1 reset");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule